// File: doc/BRIEF.md
# Segment and Page Table Translation Walker

This block turns a 32-bit virtual address into a 19-bit physical word address by walking two levels of tables held in a word-addressed physical memory. It takes one request at a time, each a read or write flag plus the virtual address. The first level, the segment table, always sits at the bottom of memory, so its entry lives at the segment index itself. That entry gives the start of a page table. The page-table entry gives the start of a page, and the word offset is added to it. Every table entry is a 32-bit word. A word with its top bit set marks the next level as not resident. A word of zero marks it as not existing. Any other word is the physical start address of the next level, always a multiple of the 512-word frame size.

A read that reaches a non-resident level ends with a page fault. A read that reaches a missing level ends with an error. A write to a missing level builds what is missing on the spot. For a missing page table it asks an external free-frame allocator for a two-frame (1024-word) block. For a missing page it asks for a single 512-word frame. It clears the new block one word per cycle and then links it into its parent entry. Parent entries are written only after every needed block has been obtained and cleared. An allocator refusal therefore leaves all existing table entries untouched.

The controller is one state machine with these states:
- S_IDLE: waits for a request.
- S_SEG_RD and S_SEG_CHK: issue and judge the segment-table read.
- S_PT_RD and S_PT_CHK: issue and judge the page-table read.
- S_ALLOC: waits for the allocator.
- S_FILL: zero-fills the new block.
- S_LINK_PT: writes the page-table entry.
- S_LINK_SEG: writes the segment-table entry.
- S_DONE: presents the result.

The transitions are these:
- S_IDLE goes to S_SEG_RD when a request arrives.
- S_SEG_CHK goes to S_PT_RD on a valid entry. It goes to S_DONE on a fault, or on an absent entry for a read. It goes to S_ALLOC on an absent entry for a write.
- S_PT_CHK goes to S_DONE on a valid entry, on a fault, or on an absent entry for a read. It goes to S_ALLOC on an absent entry for a write.
- S_ALLOC goes to S_FILL on a grant and to S_DONE on a refusal.
- S_FILL goes back to S_ALLOC after a page-table fill, so that a page is then requested. It goes to S_LINK_PT after a page fill.
- S_LINK_PT goes to S_LINK_SEG when the page table was new in this request, and to S_DONE otherwise.
- S_LINK_SEG goes to S_DONE.
- S_DONE goes to S_IDLE.

Top module: `seg_page_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken when `req_valid` and `req_ready` are both high. Each taken request produces exactly one single-cycle `done_valid` pulse, and `req_ready` stays low from acceptance until that pulse.
- R2: The virtual address fields are bits [27:19] for the segment index, bits [18:9] for the page index and bits [8:0] for the word offset. Bits [31:28] have no effect on the result.
- R3: The segment entry is read at address s. The page-table entry is read at (segment entry + p). A successful walk returns `done_code` 0 with `done_paddr` = page entry + w.
- R4: A table entry whose bit 31 is set (for example all ones) ends the request with `done_code` 1 (page fault), for reads and writes alike. It causes no memory write and no allocator request.
- R5: A zero table entry met by a read ends with `done_code` 2 (error), with no allocator request and no memory write.
- R6: A write that meets a zero page-table entry raises `alloc_req` with `alloc_table` = 0 and holds both until `alloc_ack`. It then writes zero to the 512 words from the granted base, stores the base in the page-table entry, and returns base + w.
- R7: A write that meets a zero segment entry first requests a block with `alloc_table` = 1 and zeroes its 1024 words. It then obtains and zeroes a page as in R6, writes the page entry into the new table, and writes the table base into the segment entry.
- R8: If the allocator answers with `alloc_ok` low, the request ends with `done_code` 2, and neither the segment entry nor any previously existing page-table entry is modified.
- R9: Whenever `done_code` is not 0, `done_paddr` is 0, and code value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_vaddr | input | 32 | Virtual address |
| done_valid | output | 1 | Result pulse |
| done_code | output | 2 | 0 physical address, 1 page fault, 2 error |
| done_paddr | output | 19 | Physical word address, 0 unless code is 0 |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 19 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read strobe |
| alloc_req | output | 1 | Free-frame request, held until acknowledged |
| alloc_table | output | 1 | 1 = two consecutive frames, 0 = one frame |
| alloc_ack | input | 1 | Allocator answer strobe |
| alloc_ok | input | 1 | With ack: 1 = granted, 0 = no room |
| alloc_base | input | 19 | With ack: start word address of the granted block |

## Verification
Reads are sent through resident tables with different fields, including the highest physical word and addresses whose top four bits are set, to show that the field split and the final addition are right. Entries that are not resident are placed at each level for both access kinds, to separate the fault path from the absent path. Absent entries are tried with reads and with writes, to tell an error from an allocation. The writes cover a missing page alone, a missing table plus page, a refusal at the first request, and a refusal after a table was already cleared. Sentinel words placed just past each new block show that the fill length is exact and that no parent entry is written early.

// File: rtl/spw_pkg.sv
package spw_pkg;

    // Result codes carried on done_code
    typedef enum logic [1:0] {
        RES_PA    = 2'd0,
        RES_FAULT = 2'd1,
        RES_ERR   = 2'd2
    } res_e;

    // Classification of one table word
    typedef enum logic [1:0] {
        ENT_VALID  = 2'd0,
        ENT_FAULT  = 2'd1,
        ENT_ABSENT = 2'd2
    } ent_e;

    typedef enum logic [3:0] {
        S_IDLE     = 4'd0,
        S_SEG_RD   = 4'd1,
        S_SEG_CHK  = 4'd2,
        S_PT_RD    = 4'd3,
        S_PT_CHK   = 4'd4,
        S_ALLOC    = 4'd5,
        S_FILL     = 4'd6,
        S_LINK_PT  = 4'd7,
        S_LINK_SEG = 4'd8,
        S_DONE     = 4'd9
    } walk_state_e;

endpackage

// File: rtl/spw_entry_decode.sv
module spw_entry_decode
    import spw_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int PA_W   = 19
) (
    input  logic [WORD_W-1:0] entry,
    output ent_e              kind,
    output logic [PA_W-1:0]   base
);

    // Sign bit marks a non-resident level; an all-zero word marks a missing one.
    always_comb begin
        if (entry[WORD_W-1]) begin
            kind = ENT_FAULT;
        end else if (entry == '0) begin
            kind = ENT_ABSENT;
        end else begin
            kind = ENT_VALID;
        end
        base = entry[PA_W-1:0];
    end

endmodule

// File: rtl/spw_fill_ctr.sv
module spw_fill_ctr #(
    parameter int PAGE_W = 10,
    parameter int OFF_W  = 9,
    parameter int CNT_W  = (PAGE_W > OFF_W) ? PAGE_W : OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    input  logic             table_sel,
    output logic [CNT_W-1:0] offset,
    output logic             last
);

    localparam logic [CNT_W-1:0] TBL_LAST = CNT_W'((1 << PAGE_W) - 1);
    localparam logic [CNT_W-1:0] PG_LAST  = CNT_W'((1 << OFF_W) - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset <= '0;
        end else if (start) begin
            offset <= '0;
        end else if (step) begin
            offset <= offset + 1'b1;
        end
    end

    always_comb begin
        last = (offset == (table_sel ? TBL_LAST : PG_LAST));
    end

    AST_PAGE_FILL_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        step && !table_sel |-> offset <= PG_LAST); // R6

endmodule

// File: rtl/spw_walk_fsm.sv
module spw_walk_fsm
    import spw_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int SEG_W  = 9,
    parameter int PAGE_W = 10,
    parameter int OFF_W  = 9,
    parameter int PA_W   = 19,
    parameter int WORD_W = 32,
    parameter int CNT_W  = (PAGE_W > OFF_W) ? PAGE_W : OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              done_valid,
    output logic [1:0]        done_code,
    output logic [PA_W-1:0]   done_paddr,
    output logic              mem_en,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  ent_e              ent_kind,
    input  logic [PA_W-1:0]   ent_base,
    output logic              alloc_req,
    output logic              alloc_table,
    input  logic              alloc_ack,
    input  logic              alloc_ok,
    input  logic [PA_W-1:0]   alloc_base,
    output logic              fill_start,
    output logic              fill_step,
    output logic              fill_table,
    input  logic [CNT_W-1:0]  fill_off,
    input  logic              fill_last
);

    localparam int OFF_LO  = 0;
    localparam int PAGE_LO = OFF_W;
    localparam int SEG_LO  = OFF_W + PAGE_W;

    walk_state_e       state, nxt;
    logic              cur_write;
    logic [SEG_W-1:0]  seg_idx;
    logic [PAGE_W-1:0] page_idx;
    logic [OFF_W-1:0]  word_off;
    logic [PA_W-1:0]   seg_base;
    logic [PA_W-1:0]   page_base;
    logic              pt_new;
    logic              lvl_table;
    res_e              res_code;
    logic [PA_W-1:0]   res_addr;
    logic [PA_W-1:0]   pte_addr;
    logic [PA_W-1:0]   fill_base;

    assign pte_addr  = seg_base + PA_W'(page_idx);
    assign fill_base = lvl_table ? seg_base : page_base;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (req_valid) nxt = S_SEG_RD;
            S_SEG_RD:  nxt = S_SEG_CHK;
            S_SEG_CHK: begin
                unique case (ent_kind)
                    ENT_FAULT:  nxt = S_DONE;
                    ENT_ABSENT: nxt = cur_write ? S_ALLOC : S_DONE;
                    default:    nxt = S_PT_RD;
                endcase
            end
            S_PT_RD:   nxt = S_PT_CHK;
            S_PT_CHK: begin
                unique case (ent_kind)
                    ENT_FAULT:  nxt = S_DONE;
                    ENT_ABSENT: nxt = cur_write ? S_ALLOC : S_DONE;
                    default:    nxt = S_DONE;
                endcase
            end
            S_ALLOC:   if (alloc_ack) nxt = alloc_ok ? S_FILL : S_DONE;
            S_FILL:    if (fill_last) nxt = lvl_table ? S_ALLOC : S_LINK_PT;
            S_LINK_PT: nxt = pt_new ? S_LINK_SEG : S_DONE;
            S_LINK_SEG: nxt = S_DONE;
            S_DONE:    nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // Walk context and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_write <= 1'b0;
            seg_idx   <= '0;
            page_idx  <= '0;
            word_off  <= '0;
            seg_base  <= '0;
            page_base <= '0;
            pt_new    <= 1'b0;
            lvl_table <= 1'b0;
            res_code  <= RES_PA;
            res_addr  <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        cur_write <= req_write;
                        seg_idx   <= req_vaddr[SEG_LO +: SEG_W];
                        page_idx  <= req_vaddr[PAGE_LO +: PAGE_W];
                        word_off  <= req_vaddr[OFF_LO +: OFF_W];
                        pt_new    <= 1'b0;
                        lvl_table <= 1'b0;
                        res_code  <= RES_PA;
                        res_addr  <= '0;
                    end
                end
                S_SEG_CHK: begin
                    unique case (ent_kind)
                        ENT_FAULT:  res_code <= RES_FAULT;
                        ENT_ABSENT: begin
                            if (cur_write) lvl_table <= 1'b1;
                            else           res_code  <= RES_ERR;
                        end
                        default:    seg_base <= ent_base;
                    endcase
                end
                S_PT_CHK: begin
                    unique case (ent_kind)
                        ENT_FAULT:  res_code <= RES_FAULT;
                        ENT_ABSENT: begin
                            if (cur_write) lvl_table <= 1'b0;
                            else           res_code  <= RES_ERR;
                        end
                        default: begin
                            page_base <= ent_base;
                            res_addr  <= ent_base + PA_W'(word_off);
                        end
                    endcase
                end
                S_ALLOC: begin
                    if (alloc_ack) begin
                        if (!alloc_ok) begin
                            res_code <= RES_ERR;
                        end else if (lvl_table) begin
                            seg_base <= alloc_base;
                            pt_new   <= 1'b1;
                        end else begin
                            page_base <= alloc_base;
                        end
                    end
                end
                S_FILL: begin
                    if (fill_last && lvl_table) lvl_table <= 1'b0;
                end
                S_LINK_PT: begin
                    res_addr <= page_base + PA_W'(word_off);
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready   = 1'b0;
        done_valid  = 1'b0;
        done_code   = res_code;
        done_paddr  = res_addr;
        mem_en      = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        alloc_req   = 1'b0;
        alloc_table = lvl_table;
        fill_start  = 1'b0;
        fill_step   = 1'b0;
        fill_table  = lvl_table;
        unique case (state)
            S_IDLE:  req_ready = 1'b1;
            S_SEG_RD: begin
                mem_en   = 1'b1;
                mem_addr = PA_W'(seg_idx);
            end
            S_PT_RD: begin
                mem_en   = 1'b1;
                mem_addr = pte_addr;
            end
            S_ALLOC: begin
                alloc_req  = 1'b1;
                fill_start = alloc_ack && alloc_ok;
            end
            S_FILL: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = fill_base + PA_W'(fill_off);
                fill_step = 1'b1;
            end
            S_LINK_PT: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = pte_addr;
                mem_wdata = WORD_W'(page_base);
            end
            S_LINK_SEG: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = PA_W'(seg_idx);
                mem_wdata = WORD_W'(seg_base);
            end
            S_DONE:  done_valid = 1'b1;
            default: ;
        endcase
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid); // R1

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !done_valid && !mem_en && !alloc_req); // R1

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> done_code != 2'd3); // R9

    AST_NONPA_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && done_code != RES_PA |-> done_paddr == '0); // R9

    AST_ALLOC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req && !alloc_ack |=> alloc_req && $stable(alloc_table)); // R6

    AST_READ_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |-> cur_write); // R5

    AST_FAULT_NO_NEW_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && done_code == RES_FAULT |-> !pt_new); // R4

endmodule

// File: rtl/seg_page_walker.sv
module seg_page_walker
    import spw_pkg::*;
#(
    parameter int SEG_W  = 9,
    parameter int PAGE_W = 10,
    parameter int OFF_W  = 9,
    parameter int PA_W   = 19,
    parameter int WORD_W = 32,
    parameter int VA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              done_valid,
    output logic [1:0]        done_code,
    output logic [PA_W-1:0]   done_paddr,
    output logic              mem_en,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              alloc_req,
    output logic              alloc_table,
    input  logic              alloc_ack,
    input  logic              alloc_ok,
    input  logic [PA_W-1:0]   alloc_base
);

    localparam int CNT_W = (PAGE_W > OFF_W) ? PAGE_W : OFF_W;

    ent_e             ent_kind;
    logic [PA_W-1:0]  ent_base;
    logic             fill_start;
    logic             fill_step;
    logic             fill_table;
    logic [CNT_W-1:0] fill_off;
    logic             fill_last;

    spw_entry_decode #(
        .WORD_W (WORD_W),
        .PA_W   (PA_W)
    ) u_decode (
        .entry (mem_rdata),
        .kind  (ent_kind),
        .base  (ent_base)
    );

    spw_fill_ctr #(
        .PAGE_W (PAGE_W),
        .OFF_W  (OFF_W),
        .CNT_W  (CNT_W)
    ) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (fill_start),
        .step      (fill_step),
        .table_sel (fill_table),
        .offset    (fill_off),
        .last      (fill_last)
    );

    spw_walk_fsm #(
        .VA_W   (VA_W),
        .SEG_W  (SEG_W),
        .PAGE_W (PAGE_W),
        .OFF_W  (OFF_W),
        .PA_W   (PA_W),
        .WORD_W (WORD_W),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_vaddr   (req_vaddr),
        .done_valid  (done_valid),
        .done_code   (done_code),
        .done_paddr  (done_paddr),
        .mem_en      (mem_en),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .ent_kind    (ent_kind),
        .ent_base    (ent_base),
        .alloc_req   (alloc_req),
        .alloc_table (alloc_table),
        .alloc_ack   (alloc_ack),
        .alloc_ok    (alloc_ok),
        .alloc_base  (alloc_base),
        .fill_start  (fill_start),
        .fill_step   (fill_step),
        .fill_table  (fill_table),
        .fill_off    (fill_off),
        .fill_last   (fill_last)
    );

endmodule

// File: tb/seg_page_walker_tb.sv
`timescale 1ns/1ps
module seg_page_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        done_valid;
    logic [1:0]  done_code;
    logic [18:0] done_paddr;
    logic        mem_en, mem_we;
    logic [18:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        alloc_req, alloc_table;
    logic        alloc_ack = 1'b0;
    logic        alloc_ok = 1'b0;
    logic [18:0] alloc_base = '0;

    always #4 clk = ~clk;

    seg_page_walker u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_vaddr(req_vaddr),
        .done_valid(done_valid), .done_code(done_code), .done_paddr(done_paddr),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .alloc_req(alloc_req), .alloc_table(alloc_table),
        .alloc_ack(alloc_ack), .alloc_ok(alloc_ok), .alloc_base(alloc_base)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Sparse memory model, one-cycle read latency
    logic [31:0] mem [int];
    int wr_count = 0;

    function automatic logic [31:0] rd(input int a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                mem[int'(mem_addr)] = mem_wdata;
                wr_count++;
            end else begin
                mem_rdata <= rd(int'(mem_addr));
            end
        end
    end

    // Allocator model: answers two cycles after a request
    logic [18:0] tbl_base = '0, pg_base = '0;
    logic        ok_tbl = 1'b1, ok_pg = 1'b1;
    int          alloc_dly = 0;
    int          alloc_count = 0;
    logic        last_alloc_table = 1'b0;

    always @(posedge clk) begin
        if (alloc_ack) begin
            alloc_ack <= 1'b0;
        end else if (alloc_req) begin
            if (alloc_dly == 1) begin
                alloc_ack  <= 1'b1;
                alloc_ok   <= alloc_table ? ok_tbl : ok_pg;
                alloc_base <= alloc_table ? tbl_base : pg_base;
                alloc_count++;
                last_alloc_table = alloc_table;
                alloc_dly <= 0;
            end else begin
                alloc_dly <= alloc_dly + 1;
            end
        end
    end

    int done_count = 0;
    always @(posedge clk) if (done_valid) done_count++;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_va(input int s, input int p, input int w, input logic [3:0] top);
        return {top, 9'(s), 10'(p), 9'(w)};
    endfunction

    task automatic run_req(input logic wr, input logic [31:0] va,
                           output logic [1:0] code, output logic [18:0] pa);
        bit seen;
        int busy_ready;
        seen = 0;
        busy_ready = 0;
        code = 2'd3;
        pa = '0;
        @(negedge clk);
        wr_count = 0;
        alloc_count = 0;
        done_count = 0;
        req_valid = 1'b1;
        req_write = wr;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = '0;
        for (int i = 0; i < 5000 && !seen; i++) begin
            if (done_valid) begin
                seen = 1;
                code = done_code;
                pa = done_paddr;
            end else begin
                if (req_ready) busy_ready++;
                @(negedge clk);
            end
        end
        chk("R1 done seen", 64'(seen), 64'd1);
        chk("R1 ready low while busy", 64'(busy_ready), 64'd0);
        @(negedge clk);
        chk("R1 single done pulse", 64'(done_count), 64'd1);
        chk("R1 ready after done", 64'(req_ready), 64'd1);
    endtask

    task automatic t_reset;
        chk("R1 reset ready", 64'(req_ready), 64'd1);
        chk("R1 reset done low", 64'(done_valid), 64'd0);
        chk("R4 reset mem idle", 64'(mem_en), 64'd0);
        chk("R5 reset alloc idle", 64'(alloc_req), 64'd0);
    endtask

    task automatic t_read_hits;
        logic [1:0] c; logic [18:0] a;
        mem[5] = 32'd1024;
        mem[1024 + 3] = 32'd4096;
        mem[511] = 32'd2048;
        mem[2048 + 1023] = 32'd523776;
        run_req(1'b0, mk_va(5, 3, 7, 4'h0), c, a);
        chk("R3 code", 64'(c), 64'd0);
        chk("R3 paddr", 64'(a), 64'd4103);
        run_req(1'b0, mk_va(5, 3, 7, 4'hF), c, a);
        chk("R2 top bits ignored code", 64'(c), 64'd0);
        chk("R2 top bits ignored paddr", 64'(a), 64'd4103);
        run_req(1'b0, mk_va(511, 1023, 511, 4'hA), c, a);
        chk("R2 max fields code", 64'(c), 64'd0);
        chk("R3 max paddr", 64'(a), 64'd524287);
        chk("R3 reads write nothing", 64'(wr_count), 64'd0);
    endtask

    task automatic t_faults;
        logic [1:0] c; logic [18:0] a;
        mem[6] = 32'hFFFF_FFFF;
        mem[1024 + 4] = 32'hFFFF_FFFF;
        run_req(1'b0, mk_va(6, 0, 0, 4'h0), c, a);
        chk("R4 seg fault read code", 64'(c), 64'd1);
        chk("R9 fault paddr zero", 64'(a), 64'd0);
        run_req(1'b1, mk_va(6, 2, 3, 4'h0), c, a);
        chk("R4 seg fault write code", 64'(c), 64'd1);
        chk("R4 seg fault no write", 64'(wr_count), 64'd0);
        chk("R4 seg fault no alloc", 64'(alloc_count), 64'd0);
        run_req(1'b0, mk_va(5, 4, 0, 4'h0), c, a);
        chk("R4 page fault read code", 64'(c), 64'd1);
        run_req(1'b1, mk_va(5, 4, 9, 4'h0), c, a);
        chk("R4 page fault write code", 64'(c), 64'd1);
        chk("R4 page fault write no alloc", 64'(alloc_count), 64'd0);
        chk("R4 entry kept", 64'(rd(1028)), 64'hFFFF_FFFF);
    endtask

    task automatic t_absent_reads;
        logic [1:0] c; logic [18:0] a;
        run_req(1'b0, mk_va(7, 1, 1, 4'h0), c, a);
        chk("R5 seg absent read code", 64'(c), 64'd2);
        chk("R9 err paddr zero", 64'(a), 64'd0);
        chk("R5 no alloc", 64'(alloc_count), 64'd0);
        run_req(1'b0, mk_va(5, 9, 2, 4'h0), c, a);
        chk("R5 page absent read code", 64'(c), 64'd2);
        chk("R5 no write", 64'(wr_count), 64'd0);
        chk("R5 no alloc page", 64'(alloc_count), 64'd0);
    endtask

    task automatic t_page_create;
        logic [1:0] c; logic [18:0] a;
        ok_tbl = 1'b1; ok_pg = 1'b1;
        pg_base = 19'd8192;
        mem[8192] = 32'hDEAD;
        mem[8703] = 32'hBEEF;
        mem[8704] = 32'hCAFE;
        run_req(1'b1, mk_va(5, 9, 20, 4'h0), c, a);
        chk("R6 code", 64'(c), 64'd0);
        chk("R6 paddr", 64'(a), 64'd8212);
        chk("R6 one alloc", 64'(alloc_count), 64'd1);
        chk("R6 single frame kind", 64'(last_alloc_table), 64'd0);
        chk("R6 first word zero", 64'(rd(8192)), 64'd0);
        chk("R6 last word zero", 64'(rd(8703)), 64'd0);
        chk("R6 next frame kept", 64'(rd(8704)), 64'hCAFE);
        chk("R6 entry linked", 64'(rd(1024 + 9)), 64'd8192);
        chk("R6 write count", 64'(wr_count), 64'd513);
        run_req(1'b0, mk_va(5, 9, 21, 4'h0), c, a);
        chk("R6 reuse paddr", 64'(a), 64'd8213);
        chk("R6 reuse no alloc", 64'(alloc_count), 64'd0);
    endtask

    task automatic t_table_create;
        logic [1:0] c; logic [18:0] a;
        ok_tbl = 1'b1; ok_pg = 1'b1;
        tbl_base = 19'd10240;
        pg_base = 19'd16384;
        mem[10240] = 32'h3;
        mem[11263] = 32'h1;
        mem[11264] = 32'h2;
        run_req(1'b1, mk_va(8, 2, 5, 4'h0), c, a);
        chk("R7 code", 64'(c), 64'd0);
        chk("R7 paddr", 64'(a), 64'd16389);
        chk("R7 two allocs", 64'(alloc_count), 64'd2);
        chk("R7 seg entry", 64'(rd(8)), 64'd10240);
        chk("R7 page entry", 64'(rd(10242)), 64'd16384);
        chk("R7 table head zero", 64'(rd(10240)), 64'd0);
        chk("R7 table tail zero", 64'(rd(11263)), 64'd0);
        chk("R7 beyond table kept", 64'(rd(11264)), 64'd2);
        chk("R7 write count", 64'(wr_count), 64'd1538);
    endtask

    task automatic t_alloc_fail;
        logic [1:0] c; logic [18:0] a;
        ok_tbl = 1'b0; ok_pg = 1'b1;
        run_req(1'b1, mk_va(9, 0, 0, 4'h0), c, a);
        chk("R8 table refusal code", 64'(c), 64'd2);
        chk("R8 table refusal no write", 64'(wr_count), 64'd0);
        chk("R8 seg entry untouched", 64'(rd(9)), 64'd0);
        ok_tbl = 1'b1; ok_pg = 1'b0;
        run_req(1'b1, mk_va(5, 12, 0, 4'h0), c, a);
        chk("R8 page refusal code", 64'(c), 64'd2);
        chk("R8 page entry untouched", 64'(rd(1024 + 12)), 64'd0);
        chk("R8 page refusal no write", 64'(wr_count), 64'd0);
        tbl_base = 19'd20480;
        run_req(1'b1, mk_va(10, 0, 0, 4'h0), c, a);
        chk("R8 late refusal code", 64'(c), 64'd2);
        chk("R9 late refusal paddr", 64'(a), 64'd0);
        chk("R8 late refusal seg untouched", 64'(rd(10)), 64'd0);
        chk("R8 late refusal two requests", 64'(alloc_count), 64'd2);
        chk("R8 late refusal only fill writes", 64'(wr_count), 64'd1024);
        ok_pg = 1'b1;
    endtask

    initial begin
        #1_500_000;
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_hits();
        t_faults();
        t_absent_reads();
        t_page_create();
        t_table_create();
        t_alloc_fail();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule